// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps track of cache misses that have been sent to the next memory level but have not yet returned. It lets the cache keep running while misses are pending. It holds a small pool of tracking registers. Each register is keyed by a block address and carries a short list of waiting requesters. Each list entry records the requester's tag and the word of the block that the requester wants.

A miss to a block that is not yet tracked claims a free register and starts one memory read. A miss to a block that is already being fetched joins that register's list and does not start a second read. When the whole line comes back on the fill port, the block answers every waiting requester, one per cycle, with the requested word. After the last answer the register is free again.

When every register is busy, the block raises a stall that holds back the whole cache pipeline, hits and misses alike. It also stalls a joining miss whose list is already full.

Top module: `miss_tracker`

## Requirements
- R1: After reset, with no request pending, stall, memReqValid and respValid are all low.
- R2: An accepted miss to an untracked block claims the lowest-numbered free register. In the next cycle memReqValid is high for exactly one cycle, with memReqAddr equal to the block address.
- R3: An accepted miss whose block address matches a tracked register is added as a waiting target of that register and raises no memory request. A block address is never held by two registers at once.
- R4: From the cycle after a fill, the filled register answers one target per cycle, in the order the targets arrived. Each answer gives respTag and respWord. respData is the 32-bit word at bits [respWord*32 +: 32] of the fill line.
- R5: Four distinct misses can be outstanding at once. While all four registers are busy, stall is high whatever the request inputs are, and no request is accepted.
- R6: A miss to a tracked block whose four target slots are all used sees stall high and is not recorded.
- R7: A register becomes free in the cycle after its last answer. If that freeing ends the all-busy condition, stall drops in that same cycle.
- R8: A miss that arrives in the same cycle as the fill for its block is included in that fill's answers, after the earlier targets. The same holds for a miss to a register that is still answering.
- R9: When more than one filled register has answers pending, the lowest-numbered one is served first.
- R10: A fill whose address matches no register that is waiting for data produces no answers and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Miss request present |
| reqAddr | input | 26 | Block address of the miss |
| reqWord | input | 3 | Word within the block that the requester needs |
| reqTag | input | 6 | Requester tag returned with the answer |
| stall | output | 1 | Cache pipeline must hold (request not taken) |
| memReqValid | output | 1 | Start a memory read for a new block |
| memReqAddr | output | 26 | Block address of that read |
| fillValid | input | 1 | Line returned from memory |
| fillAddr | input | 26 | Block address of the returned line |
| fillData | input | 256 | Returned line, word i at bits [i*32 +: 32] |
| respValid | output | 1 | One answer for a waiting target |
| respTag | output | 6 | Requester tag of this answer |
| respWord | output | 3 | Word offset of this answer |
| respData | output | 32 | Requested word |

## Verification
The main function is first tried with a few directed patterns. A lone miss followed by its fill shows the primary allocation and one memory request. Repeated misses to one block show merging without extra requests, and the list-full stall when a fifth target arrives. A miss placed in the same cycle as the fill shows late inclusion. A fill for an unknown block shows that such a fill is ignored. Two fills to registers taken in reverse order expose the drain priority, and four distinct blocks expose the all-busy stall and its release. Random traffic then runs over a pool of six block addresses with random fills to pending blocks. This mixes merges, preemption of a draining register and stalls in orders that the directed cases do not reach. A bench model predicts every output each cycle.

// File: rtl/miss_tracker_pkg.sv
`timescale 1ns/1ps
package miss_tracker_pkg;
  localparam int ENTRIES = 4;
  localparam int TARGETS = 4;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int SLOT_W  = $clog2(TARGETS);
  localparam int CNT_W   = $clog2(TARGETS + 1);

  typedef struct packed {
    logic [ENTRIES-1:0] alloc;
    logic [ENTRIES-1:0] append;
    logic [ENTRIES-1:0] fill;
    logic [SLOT_W-1:0]  wrSlot;
    logic               respValid;
    logic [IDX_W-1:0]   respEntry;
    logic [SLOT_W-1:0]  respSlot;
  } strobe_t;
endpackage

// File: rtl/miss_tracker_ctrl.sv
`timescale 1ns/1ps
module miss_tracker_ctrl
  import miss_tracker_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               fillValid,
  input  logic [ENTRIES-1:0] addrHit,
  input  logic [ENTRIES-1:0] fillHit,
  output logic               stall,
  output strobe_t            st
);
  logic [ENTRIES-1:0] validQ, filledQ;
  logic [CNT_W-1:0]   cntQ [ENTRIES];
  logic [SLOT_W-1:0]  rdQ  [ENTRIES];
  logic [ENTRIES-1:0] liveHit, freeOH, lastOH;
  logic [IDX_W-1:0]   hitIdx;
  logic               anyHit, hitFull, accept;

  always_comb begin
    liveHit = validQ & addrHit;
    anyHit  = |liveHit;
    hitIdx  = '0;
    freeOH  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (liveHit[e]) hitIdx = IDX_W'(e);
      if (!validQ[e]) freeOH = ENTRIES'(1) << e;
    end
    hitFull = anyHit && (cntQ[hitIdx] == CNT_W'(TARGETS));
    stall   = (&validQ) | (reqValid & hitFull);
    accept  = reqValid & ~stall;

    st        = '0;
    st.alloc  = (accept && !anyHit) ? freeOH : '0;
    st.append = (accept && anyHit) ? liveHit : '0;
    st.fill   = fillValid ? (validQ & ~filledQ & fillHit) : '0;
    st.wrSlot = anyHit ? SLOT_W'(cntQ[hitIdx]) : '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (validQ[e] && filledQ[e]) begin
        st.respValid = 1'b1;
        st.respEntry = IDX_W'(e);
      end
    end
    st.respSlot = rdQ[st.respEntry];
    for (int e = 0; e < ENTRIES; e++) begin
      lastOH[e] = st.respValid && (st.respEntry == IDX_W'(e)) &&
                  (CNT_W'(rdQ[e]) + CNT_W'(1) == cntQ[e]) && !st.append[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      filledQ <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        cntQ[e] <= '0;
        rdQ[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (st.alloc[e]) begin
          validQ[e]  <= 1'b1;
          filledQ[e] <= 1'b0;
          cntQ[e]    <= CNT_W'(1);
          rdQ[e]     <= '0;
        end else if (lastOH[e]) begin
          validQ[e]  <= 1'b0;
          filledQ[e] <= 1'b0;
          cntQ[e]    <= '0;
          rdQ[e]     <= '0;
        end else begin
          if (st.fill[e]) filledQ[e] <= 1'b1;
          if (st.append[e]) cntQ[e] <= cntQ[e] + CNT_W'(1);
          if (st.respValid && st.respEntry == IDX_W'(e)) rdQ[e] <= rdQ[e] + SLOT_W'(1);
        end
      end
    end
  end

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(validQ & addrHit));

  // R4
  resp_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.respValid && $past(st.respValid) && st.respEntry == $past(st.respEntry))
      |-> st.respSlot == SLOT_W'($past(st.respSlot) + SLOT_W'(1)));

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : gChk
      // R6
      tgt_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
        cntQ[g] <= CNT_W'(TARGETS));
      // R7
      free_after_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(validQ[g]) |-> $past(st.respValid && st.respEntry == IDX_W'(g)));
    end
  endgenerate
endmodule

// File: rtl/miss_tracker_dp.sv
`timescale 1ns/1ps
module miss_tracker_dp
  import miss_tracker_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 6,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [OFF_W-1:0]   reqWord,
  input  logic [TAG_W-1:0]   reqTag,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [LINE_W-1:0]  fillData,
  output logic [ENTRIES-1:0] addrHit,
  output logic [ENTRIES-1:0] fillHit,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [TAG_W-1:0]   respTag,
  output logic [OFF_W-1:0]   respWord,
  output logic [WORD_W-1:0]  respData
);
  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [LINE_W-1:0] lineQ [ENTRIES];
  logic [TAG_W-1:0]  tagQ  [ENTRIES][TARGETS];
  logic [OFF_W-1:0]  wordQ [ENTRIES][TARGETS];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
      assign addrHit[g] = (addrQ[g] == reqAddr);
      assign fillHit[g] = (addrQ[g] == fillAddr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (st.alloc[e]) addrQ[e] <= reqAddr;
      if (st.alloc[e] || st.append[e]) begin
        tagQ[e][st.wrSlot]  <= reqTag;
        wordQ[e][st.wrSlot] <= reqWord;
      end
      if (st.fill[e]) lineQ[e] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      memReqAddr  <= '0;
    end else begin
      memReqValid <= |st.alloc;
      if (|st.alloc) memReqAddr <= reqAddr;
    end
  end

  assign respTag  = tagQ[st.respEntry][st.respSlot];
  assign respWord = wordQ[st.respEntry][st.respSlot];
  assign respData = lineQ[st.respEntry][respWord * WORD_W +: WORD_W];
endmodule

// File: rtl/miss_tracker.sv
`timescale 1ns/1ps
module miss_tracker
  import miss_tracker_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 6,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [OFF_W-1:0]  reqWord,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              stall,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [LINE_W-1:0] fillData,
  output logic              respValid,
  output logic [TAG_W-1:0]  respTag,
  output logic [OFF_W-1:0]  respWord,
  output logic [WORD_W-1:0] respData
);
  strobe_t            st;
  logic [ENTRIES-1:0] addrHit, fillHit;

  miss_tracker_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fillValid(fillValid),
    .addrHit(addrHit), .fillHit(fillHit), .stall(stall), .st(st)
  );

  miss_tracker_dp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .TAG_W(TAG_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .reqWord(reqWord),
    .reqTag(reqTag), .fillAddr(fillAddr), .fillData(fillData),
    .addrHit(addrHit), .fillHit(fillHit), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .respTag(respTag), .respWord(respWord),
    .respData(respData)
  );

  assign respValid = st.respValid;

  // R2
  memreq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(reqValid && !stall));

  // R5
  stall_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !memReqValid);
endmodule

// File: tb/test_miss_tracker.sv
`timescale 1ns/1ps
module test_miss_tracker;
  localparam int ADDR_W = 26, WORD_W = 32, WORDS = 8, TAG_W = 6;
  localparam int OFF_W = 3, LINE_W = 256, NE = 4, NT = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, fillValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0, fillAddr = '0;
  logic [OFF_W-1:0] reqWord = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic [LINE_W-1:0] fillData = '0;
  logic stall, memReqValid, respValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic [TAG_W-1:0] respTag;
  logic [OFF_W-1:0] respWord;
  logic [WORD_W-1:0] respData;

  miss_tracker i_miss_tracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWord(reqWord), .reqTag(reqTag), .stall(stall), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .fillValid(fillValid), .fillAddr(fillAddr),
    .fillData(fillData), .respValid(respValid), .respTag(respTag),
    .respWord(respWord), .respData(respData)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit mValid[NE], mFilled[NE];
  logic [ADDR_W-1:0] mAddr[NE];
  int mCnt[NE], mRd[NE];
  logic [TAG_W-1:0] mTag[NE][NT];
  logic [OFF_W-1:0] mWord[NE][NT];
  bit expMemV = 0;
  logic [ADDR_W-1:0] expMemA = '0;

  function automatic logic [WORD_W-1:0] lineWord(logic [ADDR_W-1:0] a, int i);
    return {a[21:0], 7'h55, 3'(i)};
  endfunction

  function automatic logic [LINE_W-1:0] mkLine(logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < WORDS; i++) l[i*WORD_W +: WORD_W] = lineWord(a, i);
    return l;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One clock cycle: drive, check predicted outputs, advance model.
  task automatic step(bit rv, logic [ADDR_W-1:0] a, logic [OFF_W-1:0] w,
                      logic [TAG_W-1:0] t, bit fv, logic [ADDR_W-1:0] fa, string note);
    int hitE, allocE, respE, fillE;
    bit allBusy, fullHit, expStall, acc, lastResp;
    @(negedge clk);
    reqValid = rv; reqAddr = a; reqWord = w; reqTag = t;
    fillValid = fv; fillAddr = fa; fillData = mkLine(fa);
    #1;
    hitE = -1; allocE = -1; respE = -1; fillE = -1; allBusy = 1;
    for (int e = 0; e < NE; e++) begin
      if (mValid[e] && mAddr[e] == a) hitE = e;
      if (!mValid[e] && allocE < 0) allocE = e;
      if (!mValid[e]) allBusy = 0;
      if (mValid[e] && mFilled[e] && respE < 0) respE = e;
      if (fv && mValid[e] && !mFilled[e] && mAddr[e] == fa) fillE = e;
    end
    fullHit = (hitE >= 0) && (mCnt[hitE] == NT);
    expStall = allBusy || (rv && fullHit);
    acc = rv && !expStall;
    chk($sformatf("R5/R6/R7 stall %s", note), 64'(stall), 64'(expStall));
    chk($sformatf("R4/R9/R10 respValid %s", note), 64'(respValid), 64'(respE >= 0));
    if (respE >= 0) begin
      chk($sformatf("R4/R9 respTag %s", note), 64'(respTag), 64'(mTag[respE][mRd[respE]]));
      chk($sformatf("R4 respWord %s", note), 64'(respWord), 64'(mWord[respE][mRd[respE]]));
      chk($sformatf("R4 respData %s", note), 64'(respData),
          64'(lineWord(mAddr[respE], int'(mWord[respE][mRd[respE]]))));
    end
    chk($sformatf("R2/R3 memReqValid %s", note), 64'(memReqValid), 64'(expMemV));
    if (expMemV) chk($sformatf("R2 memReqAddr %s", note), 64'(memReqAddr), 64'(expMemA));
    lastResp = (respE >= 0) && (mRd[respE] + 1 == mCnt[respE]) && !(acc && hitE == respE);
    expMemV = acc && (hitE < 0);
    expMemA = a;
    if (acc) begin
      if (hitE >= 0) begin
        mTag[hitE][mCnt[hitE]] = t; mWord[hitE][mCnt[hitE]] = w; mCnt[hitE]++;
      end else begin
        mValid[allocE] = 1; mFilled[allocE] = 0; mAddr[allocE] = a;
        mCnt[allocE] = 1; mRd[allocE] = 0;
        mTag[allocE][0] = t; mWord[allocE][0] = w;
      end
    end
    if (fillE >= 0) mFilled[fillE] = 1;
    if (respE >= 0) begin
      mRd[respE]++;
      if (lastResp) begin
        mValid[respE] = 0; mFilled[respE] = 0; mCnt[respE] = 0; mRd[respE] = 0;
      end
    end
  endtask

  task automatic idle(int n, string note);
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, '0, note);
  endtask

  localparam logic [ADDR_W-1:0] A = 26'h0100, B = 26'h0200, C = 26'h0300;
  localparam logic [ADDR_W-1:0] D = 26'h0400, E = 26'h0500, F = 26'h0600;

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int e = 0; e < NE; e++) begin
      mValid[e] = 0; mFilled[e] = 0; mCnt[e] = 0; mRd[e] = 0; mAddr[e] = '0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 stall after reset", 64'(stall), 64'(0));
    chk("R1 respValid after reset", 64'(respValid), 64'(0));
    chk("R1 memReqValid after reset", 64'(memReqValid), 64'(0));

    // R2 primary, R3 merge, R8 miss during fill, R7 free
    step(1, A, 3'd3, 6'd1, 0, '0, "R2 primary A");
    step(1, A, 3'd5, 6'd2, 0, '0, "R3 merge A");
    idle(2, "R3 no extra request");
    step(1, A, 3'd7, 6'd3, 1, A, "R8 miss with fill");
    idle(5, "R4 R7 drain A");

    // R10 unmatched fill
    step(0, '0, '0, '0, 1, B, "R10 stray fill");
    idle(2, "R10 no answer");

    // R6 target list full
    step(1, C, 3'd0, 6'd10, 0, '0, "R6 primary C");
    for (int i = 1; i < NT; i++) step(1, C, 3'(i), 6'(10 + i), 0, '0, "R6 fill list");
    step(1, C, 3'd6, 6'd20, 0, '0, "R6 list full stall");
    step(1, C, 3'd6, 6'd20, 1, C, "R6 fill C");
    idle(6, "R6 R7 drain C");

    // R9 priority: E in lower register than D? allocate D then E, fill E then D
    step(1, D, 3'd1, 6'd30, 0, '0, "R9 D");
    step(1, E, 3'd2, 6'd31, 0, '0, "R9 E");
    step(1, E, 3'd4, 6'd32, 0, '0, "R9 E merge");
    step(0, '0, '0, '0, 1, E, "R9 fill E");
    step(0, '0, '0, '0, 1, D, "R9 fill D preempts");
    idle(5, "R9 drain");

    // R5 all busy
    step(1, A, 3'd0, 6'd40, 0, '0, "R5 A");
    step(1, B, 3'd0, 6'd41, 0, '0, "R5 B");
    step(1, C, 3'd0, 6'd42, 0, '0, "R5 C");
    step(1, D, 3'd0, 6'd43, 0, '0, "R5 D");
    step(1, E, 3'd0, 6'd44, 0, '0, "R5 fifth stalled");
    step(1, A, 3'd1, 6'd45, 0, '0, "R5 merge stalled too");
    step(0, '0, '0, '0, 1, B, "R5 fill B");
    idle(2, "R5 R7 stall release");
    step(0, '0, '0, '0, 1, A, "R5 fill A");
    step(0, '0, '0, '0, 1, C, "R5 fill C");
    step(0, '0, '0, '0, 1, D, "R5 fill D");
    idle(6, "R5 drain");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] ra, fa;
      bit rv, fv;
      int pick;
      rv = ($urandom % 3) != 0;
      ra = A + ADDR_W'(($urandom % 6) * 26'h100);
      fv = 0; fa = F;
      if (($urandom % 4) == 0) begin
        pick = int'($urandom % NE);
        for (int k = 0; k < NE; k++) begin
          int e;
          e = (pick + k) % NE;
          if (!fv && mValid[e] && !mFilled[e]) begin fv = 1; fa = mAddr[e]; end
        end
      end
      step(rv, ra, 3'($urandom), 6'($urandom), fv, fa, "random R2 R3 R4 R8 R9");
    end
    for (int k = 0; k < 60; k++) begin
      bit fv;
      logic [ADDR_W-1:0] fa;
      fv = 0; fa = F;
      for (int e = 0; e < NE; e++)
        if (!fv && mValid[e] && !mFilled[e]) begin fv = 1; fa = mAddr[e]; end
      step(0, '0, '0, '0, fv, fa, "final drain R7");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule